// File: doc/BRIEF.md
# DMA Segment Length Planner

This block splits a long transfer of 64-bit words into segments that a DMA burst engine can move without leaving awkward leftovers. Given the number of words still outstanding and the depth of the data FIFO, it returns two values. The first is the length of the next serial segment. The second is the burst length the DMA engine should use within that segment. The caller presents a request with a one-cycle `start` pulse and gets the result on a one-cycle `done` pulse.

Short transfers that fit in the FIFO go out in one piece, using one burst of the full length. Very long transfers are capped at the largest segment the burst counter can describe. Everything in between is searched for the largest burst length from 8 down to 2 that divides the remaining count exactly. If no such divisor exists, the segment is trimmed to a multiple of 8. The trimming never leaves a one-word tail for the next segment. The burst requester that consumes these values sits downstream and is not part of this block.

Top module: `seg_len_planner`

## Requirements
- R1: While reset is applied and after it is released, `done` and `busy` are 0, and `seg_len` and `burst_len` are 0.
- R2: If `remain` is less than or equal to `fifo_depth`, then `seg_len` equals `remain` and `burst_len` equals `remain`.
- R3: If `remain` equals the segment cap plus one (cap = 8 × 65535 = 524280), then `seg_len` is 524272 (the cap minus 8) and `burst_len` is 8.
- R4: If `remain` is at least the cap and is not the cap plus one, then `seg_len` is 524280 and `burst_len` is 8.
- R5: Otherwise the candidates 8, 7, 6, 5, 4, 3, 2 are tried in that order. The first candidate that divides `remain` exactly becomes `burst_len`, and `seg_len` equals `remain`.
- R6: If no candidate divides `remain`, then `seg_len` is `remain` minus (`remain` mod 8), and `burst_len` is 8.
- R7: In the R6 case, when `remain` mod 8 is 1, a further 8 is subtracted from `seg_len`, so that the remainder left over is never a single word.
- R8: `done` is high for exactly one cycle. Count N as the number of rising edges after the edge that samples `start`; `done` is high in the cycle after edge N. N is 1 for the R2, R3 and R4 cases. N is 2 + (8 − k) when candidate k is chosen, and N is 8 in the R6 case.
- R9: `busy` is high from the cycle after `start` is sampled until `done`. A `start` that arrives while `busy` is high is ignored.
- R10: `seg_len` and `burst_len` hold their values until the next `done`, whatever `remain` and `fifo_depth` do in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle request pulse, sampled only when idle |
| remain | input | 20 | Words still outstanding in the transfer |
| fifo_depth | input | 8 | FIFO depth in words; expected to be at least 8 |
| busy | output | 1 | A plan is being computed |
| done | output | 1 | One-cycle pulse: the result outputs are valid |
| seg_len | output | 20 | Words in the next segment |
| burst_len | output | 8 | DMA burst length for that segment |

## Verification
The embedded assertions check, on every cycle, the properties that do not depend on the chosen case. They cover the one-cycle `done` pulse, the strict descent of the candidate during the search, the captured request staying frozen while busy, and the results changing only together with `done`. They also check that every result above the FIFO depth is a whole number of bursts and leaves no one-word tail. Only the bench's scenarios can show which rule applies to a given length. Those rules are the exact cap-plus-one value, the search order (a length divisible by both 6 and 8 must pick 8), the trimming amounts, and the exact latency for each case. The bench checks these against values worked out by hand.

// File: rtl/spl_pkg.sv
package spl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVAL   = 2'd1,
    ST_SEARCH = 2'd2
  } spl_state_t;
endpackage

// File: rtl/spl_rst_sync.sv
module spl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/spl_divisor_flags.sv
module spl_divisor_flags #(
  parameter int LEN_W     = 20,
  parameter int CAND_W    = 4,
  parameter int BURST_MIN = 2,
  parameter int BURST_DEF = 8
) (
  input  logic [LEN_W-1:0]          value,
  output logic [(1<<CAND_W)-1:0]    hit
);
  for (genvar k = 0; k < (1 << CAND_W); k++) begin : g_cand
    if (k >= BURST_MIN && k <= BURST_DEF) begin : g_live
      assign hit[k] = ((value % LEN_W'(k)) == '0);
    end else begin : g_dead
      assign hit[k] = 1'b0;
    end
  end
endmodule

// File: rtl/spl_trim.sv
module spl_trim #(
  parameter int LEN_W     = 20,
  parameter int BURST_DEF = 8
) (
  input  logic [LEN_W-1:0] value,
  output logic [LEN_W-1:0] trimmed
);
  logic [LEN_W-1:0] tail;
  logic [LEN_W-1:0] extra;

  always_comb begin
    tail    = value % LEN_W'(BURST_DEF);
    extra   = (tail == LEN_W'(1)) ? LEN_W'(BURST_DEF) : '0;
    trimmed = value - tail - extra;
  end
endmodule

// File: rtl/seg_len_planner.sv
module seg_len_planner
  import spl_pkg::*;
#(
  parameter int LEN_W     = 20,
  parameter int FIFO_W    = 8,
  parameter int BURST_DEF = 8,
  parameter int BURST_MIN = 2,
  parameter int COUNT_MAX = 65535
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  remain,
  input  logic [FIFO_W-1:0] fifo_depth,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-1:0]  seg_len,
  output logic [FIFO_W-1:0] burst_len
);
  localparam int CAND_W = $clog2(BURST_DEF + 1);
  localparam logic [LEN_W-1:0] SEG_CAP    = LEN_W'(BURST_DEF * COUNT_MAX);
  localparam logic [LEN_W-1:0] SEG_CAP_P1 = LEN_W'(BURST_DEF * COUNT_MAX + 1);
  localparam logic [LEN_W-1:0] SEG_CAP_TR = LEN_W'(BURST_DEF * COUNT_MAX - BURST_DEF);

  logic rst_ni;
  spl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni));

  spl_state_t        state_q, state_d;
  logic [LEN_W-1:0]  rem_q;
  logic [FIFO_W-1:0] fifo_q;
  logic [CAND_W-1:0] cand_q, cand_d;
  logic [LEN_W-1:0]  seg_q, seg_d;
  logic [FIFO_W-1:0] burst_q, burst_d;
  logic              done_q, done_d;
  logic              cap_en, cand_en, out_en;

  logic [(1<<CAND_W)-1:0] div_hit;
  logic [LEN_W-1:0]       trim_len;

  spl_divisor_flags #(
    .LEN_W(LEN_W), .CAND_W(CAND_W), .BURST_MIN(BURST_MIN), .BURST_DEF(BURST_DEF)
  ) u_div (.value(rem_q), .hit(div_hit));

  spl_trim #(.LEN_W(LEN_W), .BURST_DEF(BURST_DEF)) u_trim (
    .value(rem_q), .trimmed(trim_len));

  logic fits_fifo;
  assign fits_fifo = (rem_q <= LEN_W'(fifo_q));

  // next-state logic
  always_comb begin
    state_d = state_q;
    cand_d  = cand_q;
    seg_d   = seg_q;
    burst_d = burst_q;
    done_d  = 1'b0;
    cap_en  = 1'b0;
    cand_en = 1'b0;
    out_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (fits_fifo) begin
          seg_d   = rem_q;
          burst_d = rem_q[FIFO_W-1:0];
          out_en  = 1'b1;
        end else if (rem_q == SEG_CAP_P1) begin
          seg_d   = SEG_CAP_TR;
          burst_d = FIFO_W'(BURST_DEF);
          out_en  = 1'b1;
        end else if (rem_q >= SEG_CAP) begin
          seg_d   = SEG_CAP;
          burst_d = FIFO_W'(BURST_DEF);
          out_en  = 1'b1;
        end else begin
          cand_d  = CAND_W'(BURST_DEF);
          cand_en = 1'b1;
          state_d = ST_SEARCH;
        end
        if (out_en) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_SEARCH: begin
        if (div_hit[cand_q]) begin
          seg_d   = rem_q;
          burst_d = FIFO_W'(cand_q);
          out_en  = 1'b1;
        end else if (cand_q == CAND_W'(BURST_MIN)) begin
          seg_d   = trim_len;
          burst_d = FIFO_W'(BURST_DEF);
          out_en  = 1'b1;
        end else begin
          cand_d  = cand_q - CAND_W'(1);
          cand_en = 1'b1;
        end
        if (out_en) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      fifo_q <= '0;
    end else if (cap_en) begin
      rem_q  <= remain;
      fifo_q <= fifo_depth;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cand_q <= '0;
    else if (cand_en) cand_q <= cand_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= '0;
      burst_q <= '0;
    end else if (out_en) begin
      seg_q   <= seg_d;
      burst_q <= burst_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign seg_len   = seg_q;
  assign burst_len = burst_q;

  // assertions
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  assert_capture_frozen_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> $stable(rem_q));

  assert_search_descends_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |=> (done || cand_q == $past(cand_q) - CAND_W'(1)));

  assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$stable(seg_q) || !$stable(burst_q)) |-> done);

  assert_small_whole_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && rem_q <= LEN_W'(fifo_q)) |-> (seg_len == rem_q));

  assert_whole_bursts_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && rem_q > LEN_W'(fifo_q) && burst_len != '0)
      |-> ((seg_len % LEN_W'(burst_len)) == '0));

  assert_no_single_tail_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && rem_q > LEN_W'(fifo_q) && rem_q < SEG_CAP) |-> ((rem_q - seg_len) != LEN_W'(1)));
endmodule

// File: tb/sim_seg_len_planner.sv
module sim_seg_len_planner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] remain = '0;
  logic [7:0]  fifo_depth = 8'd16;
  logic        busy, done;
  logic [19:0] seg_len;
  logic [7:0]  burst_len;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  seg_len_planner u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .remain(remain),
    .fifo_depth(fifo_depth), .busy(busy), .done(done),
    .seg_len(seg_len), .burst_len(burst_len));

  // {remain, fifo_depth, expected seg, expected burst, expected latency}
  localparam int NV = 19;
  localparam logic [63:0] VEC [NV] = '{
    {20'd5,       8'd16, 20'd5,      8'd5,  8'd1},  // R2
    {20'd16,      8'd16, 20'd16,     8'd16, 8'd1},  // R2 boundary
    {20'd0,       8'd16, 20'd0,      8'd0,  8'd1},  // R2 empty
    {20'd24,      8'd16, 20'd24,     8'd8,  8'd2},  // R5 8 before 6
    {20'd21,      8'd16, 20'd21,     8'd7,  8'd3},  // R5
    {20'd30,      8'd16, 20'd30,     8'd6,  8'd4},  // R5
    {20'd25,      8'd16, 20'd25,     8'd5,  8'd5},  // R5
    {20'd44,      8'd16, 20'd44,     8'd4,  8'd6},  // R5
    {20'd33,      8'd16, 20'd33,     8'd3,  8'd7},  // R5
    {20'd22,      8'd16, 20'd22,     8'd2,  8'd8},  // R5
    {20'd19,      8'd16, 20'd16,     8'd8,  8'd8},  // R6
    {20'd23,      8'd16, 20'd16,     8'd8,  8'd8},  // R6
    {20'd17,      8'd16, 20'd8,      8'd8,  8'd8},  // R7
    {20'd41,      8'd16, 20'd32,     8'd8,  8'd8},  // R7
    {20'd524281,  8'd16, 20'd524272, 8'd8,  8'd1},  // R3
    {20'd524280,  8'd16, 20'd524280, 8'd8,  8'd1},  // R4
    {20'd524282,  8'd16, 20'd524280, 8'd8,  8'd1},  // R4
    {20'd1048575, 8'd16, 20'd524280, 8'd8,  8'd1},  // R4
    {20'd524279,  8'd16, 20'd524279, 8'd7,  8'd3}   // R5 just below cap
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // issue one request and measure latency in edges after the sampling edge
  task automatic run(input logic [19:0] r, input logic [7:0] f, output int lat);
    @(negedge clk);
    remain = r; fifo_depth = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    int lat;
    logic [19:0] held_seg;
    logic [7:0]  held_burst;

    repeat (3) @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R1 flags in reset", {done, busy}, 0);
    check(seg_len == 0 && burst_len == 0, "R1 outputs in reset", seg_len, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R1 flags after reset", {done, busy}, 0);
    check(seg_len == 0 && burst_len == 0, "R1 outputs after reset", burst_len, 0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][63:44], VEC[i][43:36], lat);
      check(seg_len == VEC[i][35:16], $sformatf("R2-7 seg vec%0d", i), seg_len, VEC[i][35:16]);
      check(burst_len == VEC[i][15:8], $sformatf("R5 burst vec%0d", i), burst_len, VEC[i][15:8]);
      check(lat == int'(VEC[i][7:0]), $sformatf("R8 latency vec%0d", i), lat, VEC[i][7:0]);
      @(negedge clk);
      check(done == 1'b0, $sformatf("R8 pulse vec%0d", i), done, 0);
    end

    // R9: start while busy is ignored
    @(negedge clk);
    remain = 20'd22; fifo_depth = 8'd16; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    @(negedge clk);
    remain = 20'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 8, "R9 latency unaffected", lat, 8);
    check(seg_len == 20'd22 && burst_len == 8'd2, "R9 second start ignored", seg_len, 22);
    check(busy == 1'b0, "R9 busy low at done", busy, 0);

    // R10: outputs hold without a new start
    held_seg = seg_len; held_burst = burst_len;
    remain = 20'd999; fifo_depth = 8'd200;
    repeat (6) @(negedge clk);
    check(seg_len == held_seg, "R10 seg held", seg_len, held_seg);
    check(burst_len == held_burst, "R10 burst held", burst_len, held_burst);
    check(done == 1'b0 && busy == 1'b0, "R10 idle without start", {done, busy}, 0);

    // R2 with a larger FIFO depth
    run(20'd40, 8'd64, lat);
    check(seg_len == 20'd40 && burst_len == 8'd40, "R2 deep fifo", seg_len, 40);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule